// File: doc/BRIEF.md
# Staged UART Line Control Register

This block holds the line-control settings of a UART on a simple 32-bit memory-mapped bus. The settings form one 23-bit control value. It is reached through three word registers: a high word with the frame-format fields, and a mid and a low word that each carry one byte of the baud divisor. Writes to the mid and low words go only into holding (shadow) registers. The whole working value is loaded in a single cycle, on the write of the high word.

Software changes the divisor by writing the low and mid words in either order and then writing the high word. To change only one divisor byte, it writes that byte and then the high word. The serial engine reads the committed fields from output ports that stay stable between high-word writes, so it never sees a half-updated setting.

Byte offsets are 0x0 for the high word, 0x4 for the mid word and 0x8 for the low word. Offset 0xC is unmapped. Address bits [1:0] are ignored. A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled, and `bus_rdata` holds that value until the next read.

Top module: `uart_lcr_stage`

## Requirements
- R1: After reset, every field output is zero and reads of all three words return zero.
- R2: A write to the mid (0x4) or low (0x8) word never changes any field output.
- R3: A high-word write loads the high fields from its write data. In the same cycle it loads `divisor` as {mid shadow, low shadow}. All outputs change together, one cycle after the write is sampled.
- R4: Writing low then mid, or mid then low, followed by the same high-word write, gives identical outputs.
- R5: After writing only one of the mid or low words and then the high word, the other divisor byte keeps the shadow value it last held.
- R6: High-word fields: bits 6:5 are the word length (11 = 8 data bits, 10 = 7, 01 = 6, 00 = 5), bit 4 is FIFO enable, bit 3 selects two stop bits, bit 2 selects even parity, bit 1 enables parity, and bit 0 forces a break.
- R7: High-word bits 31:7 and mid/low bits 31:8 are ignored on write and read as zero. Writes to offset 0xC have no effect, and reads of offset 0xC return zero.
- R8: A read of the mid or low word returns the last value written to its shadow, even before that value is committed. A read of the high word returns the committed high fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| word_len | output | 2 | Committed word-length code |
| fifo_en | output | 1 | Committed FIFO enable |
| two_stop | output | 1 | Committed two-stop-bit select |
| even_par | output | 1 | Committed even-parity select |
| par_en | output | 1 | Committed parity enable |
| send_brk | output | 1 | Committed break control |
| divisor | output | 16 | Committed divisor {mid, low} |

## Verification
The hardest state to reach is a shadow that differs from the committed divisor while the other shadow holds an older value. In that state, a wrong commit path or a cross-wired shadow gives a wrong result that still looks plausible. The bench reaches it by committing one divisor and then rewriting only one shadow. It then checks three things: that the outputs have not moved, that readback shows the new shadow, and that after the high write only that byte of `divisor` changed. Writing the same data in both shadow orders and comparing the committed outputs rules out any dependence on order.

// File: rtl/uart_lcr_pkg.sv
package uart_lcr_pkg;
  localparam int BUS_W  = 32;
  localparam int SEG_W  = 8;
  localparam int HI_W   = 7;
  localparam int DIV_W  = 2 * SEG_W;
  localparam int CTRL_W = HI_W + DIV_W;

  localparam logic [1:0] IDX_HI  = 2'd0;
  localparam logic [1:0] IDX_MID = 2'd1;
  localparam logic [1:0] IDX_LO  = 2'd2;

  typedef struct packed {
    logic [1:0]       wlen;
    logic             fifo_on;
    logic             stop2;
    logic             par_even;
    logic             par_on;
    logic             brk;
    logic [DIV_W-1:0] div;
  } lcr_t;
endpackage

// File: rtl/lcr_decode.sv
module lcr_decode #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              wr_hi,
  output logic [1:0]        wr_seg,
  output logic [1:0]        idx
);
  import uart_lcr_pkg::*;

  always_comb begin
    idx       = addr[3:2];
    wr_hi     = wr && (idx == IDX_HI);
    wr_seg[1] = wr && (idx == IDX_MID);
    wr_seg[0] = wr && (idx == IDX_LO);
  end
endmodule

// File: rtl/lcr_shadow.sv
module lcr_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lcr_commit.sv
module lcr_commit
  import uart_lcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [HI_W-1:0]  hi_in,
  input  logic [DIV_W-1:0] div_in,
  output lcr_t             cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (strobe) begin
      cur.wlen     <= hi_in[6:5];
      cur.fifo_on  <= hi_in[4];
      cur.stop2    <= hi_in[3];
      cur.par_even <= hi_in[2];
      cur.par_on   <= hi_in[1];
      cur.brk      <= hi_in[0];
      cur.div      <= div_in;
    end
  end
endmodule

// File: rtl/uart_lcr_stage.sv
module uart_lcr_stage
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [1:0]        word_len,
  output logic              fifo_en,
  output logic              two_stop,
  output logic              even_par,
  output logic              par_en,
  output logic              send_brk,
  output logic [DIV_W-1:0]  divisor
);
  logic             wr_hi;
  logic [1:0]       wr_seg;
  logic [1:0]       idx;
  logic [SEG_W-1:0] shad [2];
  lcr_t             cur;
  logic [HI_W-1:0]  hi_view;
  logic [BUS_W-1:0] rd_next;

  lcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wr_hi(wr_hi), .wr_seg(wr_seg), .idx(idx)
  );

  // shad[0] = low byte, shad[1] = mid byte
  for (genvar g = 0; g < 2; g++) begin : g_shadow
    lcr_shadow #(.W(SEG_W)) u_sh (
      .clk(clk), .rst(rst), .load(wr_seg[g]),
      .d(bus_wdata[SEG_W-1:0]), .q(shad[g])
    );
  end

  lcr_commit u_cmt (
    .clk(clk), .rst(rst), .strobe(wr_hi),
    .hi_in(bus_wdata[HI_W-1:0]), .div_in({shad[1], shad[0]}), .cur(cur)
  );

  assign hi_view = {cur.wlen, cur.fifo_on, cur.stop2, cur.par_even, cur.par_on, cur.brk};

  always_comb begin
    rd_next = '0;
    case (idx)
      IDX_HI:  rd_next[HI_W-1:0]  = hi_view;
      IDX_MID: rd_next[SEG_W-1:0] = shad[1];
      IDX_LO:  rd_next[SEG_W-1:0] = shad[0];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign word_len = cur.wlen;
  assign fifo_en  = cur.fifo_on;
  assign two_stop = cur.stop2;
  assign even_par = cur.par_even;
  assign par_en   = cur.par_on;
  assign send_brk = cur.brk;
  assign divisor  = cur.div;
endmodule

// File: rtl/uart_lcr_stage_chk.sv
module uart_lcr_stage_chk
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [1:0]        word_len,
  input logic              fifo_en,
  input logic              two_stop,
  input logic              even_par,
  input logic              par_en,
  input logic              send_brk,
  input logic [DIV_W-1:0]  divisor,
  input logic [SEG_W-1:0]  sh_lo,
  input logic [SEG_W-1:0]  sh_mid
);
  logic hi_wr;
  logic [CTRL_W-1:0] outs;
  assign hi_wr = bus_wr && (bus_addr[3:2] == IDX_HI);
  assign outs  = {word_len, fifo_en, two_stop, even_par, par_en, send_brk, divisor};

  AST_HOLD_NO_HI_WR: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(outs)); // R2
  AST_DIV_FROM_SHADOW: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> divisor == $past({sh_mid, sh_lo})); // R3
  AST_HI_FIELDS: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> {word_len, fifo_en, two_stop, even_par, par_en, send_brk}
              == $past(bus_wdata[HI_W-1:0])); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == IDX_HI) |=> bus_rdata[BUS_W-1:HI_W] == '0); // R7
  AST_SHADOW_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == IDX_LO) |=> bus_rdata == {{(BUS_W-SEG_W){1'b0}}, $past(sh_lo)}); // R8
endmodule

bind uart_lcr_stage uart_lcr_stage_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .word_len(word_len), .fifo_en(fifo_en),
  .two_stop(two_stop), .even_par(even_par), .par_en(par_en), .send_brk(send_brk),
  .divisor(divisor), .sh_lo(shad[0]), .sh_mid(shad[1])
);

// File: tb/tb_uart_lcr_stage.sv
module tb_uart_lcr_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_HI = 4'h0, A_MID = 4'h4, A_LO = 4'h8, A_BAD = 4'hC;

  logic        clk = 0;
  logic        rst;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  word_len;
  logic        fifo_en, two_stop, even_par, par_en, send_brk;
  logic [15:0] divisor;

  int checks = 0, errors = 0;

  uart_lcr_stage dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .word_len(word_len), .fifo_en(fifo_en),
    .two_stop(two_stop), .even_par(even_par), .par_en(par_en), .send_brk(send_brk),
    .divisor(divisor)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {9'd0, word_len, fifo_en, two_stop, even_par, par_en, send_brk, divisor};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs", outs(), 32'h0);
    rd(A_HI, d);  check("R1 read hi", d, 0);
    rd(A_MID, d); check("R1 read mid", d, 0);
    rd(A_LO, d);  check("R1 read lo", d, 0);
  endtask

  task automatic t_order();
    logic [31:0] a, b;
    wr(A_LO, 32'h34); check("R2 after lo write", outs(), 0);
    wr(A_MID, 32'h12); check("R2 after mid write", outs(), 0);
    wr(A_HI, 32'h6B);
    check("R3 commit", outs(), {9'd0, 7'h6B, 16'h1234});
    a = outs();
    wr(A_HI, 32'h00);
    wr(A_MID, 32'h12); wr(A_LO, 32'h34); wr(A_HI, 32'h6B);
    b = outs();
    check("R4 order independent", b, a);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(A_LO, 32'hA5);
    check("R2 lo staged only", outs(), {9'd0, 7'h6B, 16'h1234});
    rd(A_LO, d);  check("R8 lo shadow read", d, 32'hA5);
    rd(A_HI, d);  check("R8 hi committed read", d, 32'h6B);
    wr(A_HI, 32'h15);
    check("R5 mid kept", outs(), {9'd0, 7'h15, 16'h12A5});
    wr(A_MID, 32'h7E); wr(A_HI, 32'h15);
    check("R5 lo kept", outs(), {9'd0, 7'h15, 16'h7EA5});
  endtask

  task automatic t_fields();
    for (int i = 0; i < 7; i++) begin
      wr(A_HI, 32'h1 << i);
      check($sformatf("R6 bit %0d", i), outs(), {9'd0, 7'(1 << i), 16'h7EA5});
    end
    wr(A_HI, 32'h40); check("R6 wlen=10 (7 bits)", {30'd0, word_len}, 2);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_HI, 32'hFFFF_FF80);
    check("R7 hi reserved ignored", outs(), {9'd0, 7'h00, 16'h7EA5});
    rd(A_HI, d); check("R7 hi reads zero", d, 0);
    wr(A_MID, 32'hDEAD_BE3C);
    rd(A_MID, d); check("R7 mid upper zero", d, 32'h3C);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, d); check("R7 unmapped read", d, 0);
    rd(A_LO, d);  check("R7 unmapped write ignored lo", d, 32'hA5);
    rd(A_MID, d); check("R7 unmapped write ignored mid", d, 32'h3C);
    check("R7 unmapped write outputs", outs(), {9'd0, 7'h00, 16'h7EA5});
  endtask

  initial begin
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_order();
    t_single();
    t_fields();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule